// File: doc/BRIEF.md
# Pin-Selectable Edge Interrupt Source

This block turns one line of a 32-wide bank of general-purpose inputs into an interrupt request. A configuration word picks the line, the kind of transition that counts, and whether requests may leave the block at all. The chosen line is brought into the system clock domain and compared with its level one cycle earlier. Each qualifying transition yields one request pulse, one clock cycle long, for a downstream grouped interrupt expander.

Every input of the bank passes through its own two-flop synchronizer before selection. Because of this, switching to another line never samples a half-settled value. The edge history is reloaded from the newly chosen line on every configuration write. The configuration sits behind a single write strobe that loads all three fields together. Select value s corresponds to general-purpose pin 32+s; for example, value 18 picks pin 50.

Top module: `irq_edge_select`

## Requirements
- R1: With mode code 2'b00, only a high-to-low transition of the selected line produces a request.
- R2: With mode code 2'b01, only a low-to-high transition of the selected line produces a request.
- R3: Mode code 2'b10 behaves exactly like 2'b00: falling transitions only.
- R4: With mode code 2'b11, both rising and falling transitions produce requests.
- R5: With the enable field at 0 no request is produced. Reset clears enable, mode and select to 0 and holds `irq_o` low.
- R6: Select value s (0 to 31) makes `pins_i[s]`, general-purpose pin 32+s, the source.
- R7: Transitions on any line other than the selected one produce no request.
- R8: Inputs are sampled at each rising clock edge. A transition first sampled at edge k drives `irq_o` high from edge k+2 until edge k+3, which is SYNC_STAGES+1 edges of latency.
- R9: Each qualifying transition yields exactly one single-cycle pulse. Transitions on consecutive cycles yield pulses on consecutive cycles.
- R10: A configuration write never causes a request by itself, even when the old and new selected lines differ in level. `irq_o` is low in the cycle after any write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pins_i | input | NUM_PINS | Asynchronous general-purpose input bank |
| cfg_we | input | 1 | Loads all configuration fields on this edge |
| cfg_en_i | input | 1 | Request enable value to load |
| cfg_mode_i | input | 2 | Edge mode code to load (00/10 fall, 01 rise, 11 both) |
| cfg_sel_i | input | SEL_W | Index of the source line to load |
| irq_o | output | 1 | One-cycle interrupt request pulse |

## Verification
The bench builds the block with its defaults: NUM_PINS of 32, giving a 5-bit select, and SYNC_STAGES of 2. These values bring the full select range into reach, including both ends (0 and 31) and index 18 for pin 50. They also fix the expected latency at three edges, which the scoreboard predicts for every pulse. Configuration writes between lines of unequal level, back-to-back toggles in both-edges mode, and toggles on unselected neighbours are all driven at these sizes.

// File: rtl/irq_edge_pkg.sv
// Shared types for the pin-selectable edge interrupt source.
// Assumes mode codes are decoded only through mode_hits.
package irq_edge_pkg;

    typedef enum logic [1:0] {
        EDGE_FALL_A = 2'b00,
        EDGE_RISE   = 2'b01,
        EDGE_FALL_B = 2'b10,
        EDGE_ANY    = 2'b11
    } edge_mode_e;

    // Decide whether the observed transition counts under the given mode.
    function automatic logic mode_hits(edge_mode_e m, logic rise, logic fall);
        logic r;
        unique case (m)
            EDGE_FALL_A: r = fall;
            EDGE_RISE:   r = rise;
            EDGE_FALL_B: r = fall;
            EDGE_ANY:    r = rise | fall;
            default:     r = 1'b0;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/pin_bank_sync.sv
// Per-line multi-flop synchronizer for a bank of asynchronous inputs.
// Assumes each line is independent; no cross-line coherence is given.
module pin_bank_sync #(
    parameter int WIDTH  = 32,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);
    logic [WIDTH-1:0] stage_q [STAGES];

    genvar s;
    generate
        for (s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                // Capture the raw bank into the first flop rank.
                always_ff @(posedge clk) begin
                    if (!rst_n) stage_q[0] <= '0;
                    else        stage_q[0] <= async_i;
                end
            end else begin : g_next
                // Shift the previous rank forward one cycle.
                always_ff @(posedge clk) begin
                    if (!rst_n) stage_q[s] <= '0;
                    else        stage_q[s] <= stage_q[s-1];
                end
            end
        end
    endgenerate

    assign sync_o = stage_q[STAGES-1];
endmodule

// File: rtl/pin_pick_mux.sv
// Selects one line of a bank by index using an AND-OR tree.
// Assumes indices at or above WIDTH select nothing (output 0).
module pin_pick_mux #(
    parameter int WIDTH = 32,
    parameter int SEL_W = 5
) (
    input  logic [WIDTH-1:0] bank_i,
    input  logic [SEL_W-1:0] sel_i,
    output logic             pick_o
);
    logic [WIDTH-1:0] gated;

    genvar i;
    generate
        for (i = 0; i < WIDTH; i++) begin : g_line
            assign gated[i] = bank_i[i] & (sel_i == SEL_W'(i));
        end
    endgenerate

    assign pick_o = |gated;
endmodule

// File: rtl/edge_qualify.sv
// Compares the selected level with its history and emits a registered
// one-cycle request for transitions the mode accepts.
// Assumes reload_i is high exactly in cycles where configuration is written;
// reload_level_i is then the synchronized level of the newly chosen line.
module edge_qualify
    import irq_edge_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       level_i,
    input  logic       reload_i,
    input  logic       reload_level_i,
    input  edge_mode_e mode_i,
    input  logic       en_i,
    output logic       irq_o
);
    logic prev_q;
    logic irq_q;
    logic rise;
    logic fall;
    logic hit;

    // Classify the transition between history and current level.
    always_comb begin
        rise = level_i & ~prev_q;
        fall = ~level_i & prev_q;
        hit  = mode_hits(mode_i, rise, fall);
    end

    // Track history; on a write, take it from the newly chosen line.
    always_ff @(posedge clk) begin
        if (!rst_n)        prev_q <= 1'b0;
        else if (reload_i) prev_q <= reload_level_i;
        else               prev_q <= level_i;
    end

    // Register the request, suppressed while disabled or being reconfigured.
    always_ff @(posedge clk) begin
        if (!rst_n) irq_q <= 1'b0;
        else        irq_q <= en_i & hit & ~reload_i;
    end

    assign irq_o = irq_q;

    assert_no_req_after_write_R10: assert property (@(posedge clk) disable iff (!rst_n)
        reload_i |=> !irq_q);

    assert_disabled_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !en_i |=> !irq_q);

    // Covers R3 as well: both falling codes.
    assert_fall_only_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_q && (mode_i != EDGE_RISE) && (mode_i != EDGE_ANY) && !$past(reload_i, 2))
        |-> (!$past(level_i) && $past(level_i, 2)));

    assert_rise_only_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_q && (mode_i == EDGE_RISE) && !$past(reload_i, 2))
        |-> ($past(level_i) && !$past(level_i, 2)));

    assert_any_edge_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_q && (mode_i == EDGE_ANY) && !$past(reload_i, 2))
        |-> ($past(level_i) != $past(level_i, 2)));
endmodule

// File: rtl/irq_edge_select.sv
// Top: configuration register, per-line synchronizers, line selection and
// edge qualification. Produces one-cycle requests on qualifying transitions.
// Assumes pins_i is asynchronous and cfg_* are synchronous to clk.
module irq_edge_select
    import irq_edge_pkg::*;
#(
    parameter int NUM_PINS    = 32,
    parameter int SYNC_STAGES = 2,
    localparam int SEL_W      = $clog2(NUM_PINS)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_PINS-1:0] pins_i,
    input  logic                cfg_we,
    input  logic                cfg_en_i,
    input  logic [1:0]          cfg_mode_i,
    input  logic [SEL_W-1:0]    cfg_sel_i,
    output logic                irq_o
);
    logic                en_q;
    edge_mode_e          mode_q;
    logic [SEL_W-1:0]    sel_q;
    logic [NUM_PINS-1:0] synced;
    logic                cur_level;
    logic                new_level;

    // Hold the configuration fields, loaded together on a write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q   <= 1'b0;
            mode_q <= EDGE_FALL_A;
            sel_q  <= '0;
        end else if (cfg_we) begin
            en_q   <= cfg_en_i;
            mode_q <= edge_mode_e'(cfg_mode_i);
            sel_q  <= cfg_sel_i;
        end
    end

    pin_bank_sync #(.WIDTH(NUM_PINS), .STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (pins_i),
        .sync_o  (synced)
    );

    pin_pick_mux #(.WIDTH(NUM_PINS), .SEL_W(SEL_W)) u_pick_cur (
        .bank_i (synced),
        .sel_i  (sel_q),
        .pick_o (cur_level)
    );

    pin_pick_mux #(.WIDTH(NUM_PINS), .SEL_W(SEL_W)) u_pick_new (
        .bank_i (synced),
        .sel_i  (cfg_sel_i),
        .pick_o (new_level)
    );

    edge_qualify u_edge (
        .clk            (clk),
        .rst_n          (rst_n),
        .level_i        (cur_level),
        .reload_i       (cfg_we),
        .reload_level_i (new_level),
        .mode_i         (mode_q),
        .en_i           (en_q),
        .irq_o          (irq_o)
    );

    assert_write_silent_R10: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_we |=> !irq_o);

    assert_write_disable_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && !cfg_en_i) |=> ##1 !irq_o);
endmodule

// File: tb/test_irq_edge_select.sv
module test_irq_edge_select;
    localparam int NP  = 32;
    localparam int SW  = 5;
    localparam int LAT = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NP-1:0] pins = '0;
    logic          we = 1'b0;
    logic          en = 1'b0;
    logic [1:0]    mode = 2'b00;
    logic [SW-1:0] sel = '0;
    logic          irq;

    int cyc = 0;
    int checks = 0;
    int errors = 0;
    int spurious = 0;

    typedef struct {int at; string tag;} exp_t;
    exp_t exp_q[$];

    irq_edge_select i_irq_edge_select (
        .clk(clk), .rst_n(rst_n), .pins_i(pins), .cfg_we(we),
        .cfg_en_i(en), .cfg_mode_i(mode), .cfg_sel_i(sel), .irq_o(irq)
    );

    always #2 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    // Monitor: compare observed pulses with the expected queue.
    always @(negedge clk) begin
        if (exp_q.size() > 0 && exp_q[0].at < cyc) begin
            checks++; errors++;
            $display("FAIL %s: missing pulse, actual none expected at cycle %0d",
                     exp_q[0].tag, exp_q[0].at);
            void'(exp_q.pop_front());
        end
        if (irq) begin
            if (exp_q.size() > 0 && exp_q[0].at == cyc) begin
                checks++;
                void'(exp_q.pop_front());
            end else begin
                spurious++;
            end
        end
    end

    task automatic cfg(input logic e, input logic [1:0] m, input int s);
        @(negedge clk);
        we = 1'b1; en = e; mode = m; sel = SW'(s);
        @(negedge clk);
        we = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    // Driver: change a line and push the expected pulse, if any.
    task automatic drive(input int idx, input logic v, input bit expect_pulse, input string tag);
        exp_t e;
        @(negedge clk);
        pins[idx] = v;
        if (expect_pulse) begin
            e.at = cyc + LAT; e.tag = tag;
            exp_q.push_back(e);
        end
    endtask

    task automatic quiet(input string tag);
        repeat (LAT + 3) @(negedge clk);
        checks++;
        if (spurious != 0) begin
            errors++;
            $display("FAIL %s: unexpected pulses actual %0d expected 0", tag, spurious);
        end
        spurious = 0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        checks++;
        if (irq !== 1'b0) begin
            errors++;
            $display("FAIL R5: irq during reset actual %b expected 0", irq);
        end
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        checks++;
        if (irq !== 1'b0) begin
            errors++;
            $display("FAIL R5: irq after reset actual %b expected 0", irq);
        end
        // Reset leaves requests disabled.
        drive(0, 1'b1, 0, "R5"); drive(0, 1'b0, 0, "R5");
        quiet("R5");

        // R1: mode 00, pin 50 (index 18)
        cfg(1'b1, 2'b00, 18);
        drive(18, 1'b1, 0, "R1"); repeat (5) @(negedge clk);
        drive(18, 1'b0, 1, "R1");
        quiet("R1");

        // R2 rising only; the pulse time also checks R8 latency.
        cfg(1'b1, 2'b01, 18);
        drive(18, 1'b1, 1, "R8"); repeat (5) @(negedge clk);
        drive(18, 1'b0, 0, "R2");
        quiet("R2");

        // R3: code 10 falling only
        cfg(1'b1, 2'b10, 18);
        drive(18, 1'b1, 0, "R3"); repeat (5) @(negedge clk);
        drive(18, 1'b0, 1, "R3");
        quiet("R3");

        // R4: both edges
        cfg(1'b1, 2'b11, 18);
        drive(18, 1'b1, 1, "R4"); repeat (5) @(negedge clk);
        drive(18, 1'b0, 1, "R4");
        quiet("R4");

        // R9: back-to-back toggles give consecutive single pulses
        drive(18, 1'b1, 1, "R9");
        drive(18, 1'b0, 1, "R9");
        drive(18, 1'b1, 1, "R9");
        quiet("R9");
        drive(18, 1'b0, 1, "R9");
        quiet("R9");

        // R7: unselected neighbours and bank ends ignored
        drive(17, 1'b1, 0, "R7"); drive(19, 1'b1, 0, "R7");
        drive(0, 1'b1, 0, "R7");  drive(31, 1'b1, 0, "R7");
        drive(17, 1'b0, 0, "R7"); drive(19, 1'b0, 0, "R7");
        drive(0, 1'b0, 0, "R7");  drive(31, 1'b0, 0, "R7");
        quiet("R7");

        // R6: select ends of the range
        cfg(1'b1, 2'b11, 31);
        drive(31, 1'b1, 1, "R6"); repeat (5) @(negedge clk);
        drive(31, 1'b0, 1, "R6");
        quiet("R6");
        cfg(1'b1, 2'b01, 0);
        drive(0, 1'b1, 1, "R6"); drive(18, 1'b1, 0, "R6");
        quiet("R6");

        // R10: writes between lines of unequal level are silent
        drive(5, 1'b1, 0, "R10"); drive(6, 1'b0, 0, "R10");
        drive(0, 1'b0, 0, "R10"); drive(18, 1'b0, 0, "R10");
        quiet("R10");
        cfg(1'b1, 2'b11, 5);
        cfg(1'b1, 2'b11, 6);
        cfg(1'b1, 2'b11, 5);
        cfg(1'b1, 2'b00, 6);
        cfg(1'b1, 2'b01, 5);
        quiet("R10");

        // R5: disabled line stays quiet under both-edge mode
        cfg(1'b0, 2'b11, 5);
        drive(5, 1'b0, 0, "R5"); repeat (3) @(negedge clk);
        drive(5, 1'b1, 0, "R5");
        quiet("R5");

        checks++;
        if (exp_q.size() != 0) begin
            errors++;
            $display("FAIL R9: pending pulses actual %0d expected 0", exp_q.size());
        end
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(200000 * 4);
        checks++; errors++;
        $display("FAIL R1-watchdog: run did not end, actual hung expected done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule